// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a register interface and an I2C master bus engine. Software pushes 9-bit entries through one data/command port. When bit 8 of an entry is clear, bits 7:0 are a byte to transmit. When bit 8 is set, the entry asks the engine to read one byte. The entries wait in a command FIFO until the engine takes them. The engine takes them through a valid/ready handshake.

Bytes that the engine receives go into a second FIFO. Software pops them by reading the same port. Both fill levels are visible at all times. Two status flags are computed from the levels and two programmable thresholds: one asks for more commands and one reports that data is waiting. A transmit abort from the engine empties both FIFOs in one cycle. Overflow and underflow events are reported as single-cycle pulses.

Top module: `i2c_cmdq`

## Requirements
- R1: A port write with bit 8 clear queues bits 7:0 as a transmit byte. The engine sees the entries in write order on `cmd_data_o`, with bit 8 = 0. `cmd_valid_o` is high exactly when the command level is non-zero.
- R2: A port write with bit 8 set queues a read request. It reaches the engine with `cmd_data_o[8]` = 1 and the low bits as written.
- R3: A port read pops the oldest received byte. `rd_data_o` shows that byte from the cycle after the read.
- R4: `tx_level_o` and `rx_level_o` give the entry counts of the two FIFOs. Both are 0 after reset and change in the cycle after the operation. Neither ever exceeds DEPTH.
- R5: `tx_empty_o` is high exactly when `tx_level_o` is less than or equal to `tx_thresh_i`.
- R6: `rx_full_o` is high exactly when `rx_level_o` is greater than `rx_thresh_i`. A threshold of 0 therefore flags a single byte.
- R7: `abort_i` empties both FIFOs: both levels are 0 in the next cycle. Any push or pop in the abort cycle is ignored and raises no event.
- R8: A port write while the command FIFO holds DEPTH entries is dropped, even if the engine takes an entry in the same cycle. `tx_over_o` pulses for one cycle after it.
- R9: A port read while the receive FIFO is empty returns 0 on `rd_data_o` and pulses `rx_under_o` for one cycle.
- R10: A byte that arrives while the receive FIFO holds DEPTH entries is dropped and pulses `rx_over_o` for one cycle.
- R11: A push and a pop on the same FIFO in one cycle, with neither blocked, leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the data/command port |
| wr_data_i | input | 9 | Entry to queue; bit 8 set means read request |
| rd_en_i | input | 1 | Read strobe for the data/command port |
| rd_data_o | output | 8 | Byte popped by the last read, or 0 on underflow |
| tx_thresh_i | input | LVL_W | Threshold for the command FIFO flag |
| rx_thresh_i | input | LVL_W | Threshold for the receive FIFO flag |
| cmd_valid_o | output | 1 | Command FIFO holds an entry for the engine |
| cmd_data_o | output | 9 | Oldest command entry |
| cmd_ready_i | input | 1 | Engine takes the oldest entry |
| rx_valid_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| abort_i | input | 1 | Transmit abort; empties both FIFOs |
| tx_level_o | output | LVL_W | Command FIFO entry count |
| rx_level_o | output | LVL_W | Receive FIFO entry count |
| tx_empty_o | output | 1 | Command level is at or below its threshold |
| rx_full_o | output | 1 | Receive level is above its threshold |
| tx_over_o | output | 1 | Pulse: a write was dropped on a full FIFO |
| rx_under_o | output | 1 | Pulse: a read hit an empty FIFO |
| rx_over_o | output | 1 | Pulse: a received byte was dropped |

## Verification
A wrong pointer or count shows at the ports one cycle after the faulty operation. It can appear as a level that disagrees with the number of accepted pushes and pops. It can also appear as a byte that comes out of order, or a flag that switches on the wrong side of its threshold. After every operation the bench sweeps both thresholds over every encodable value, so an off-by-one in a comparison cannot hide. A flush that leaves a pointer behind shows on the first entry queued after the abort. A full or empty decision taken on the wrong count shows as a missing or spurious event pulse in the cycle that follows.

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = BYTE_W + 1;

  typedef struct packed {
    logic              is_read;
    logic [BYTE_W-1:0] payload;
  } cmd_t;
endpackage

// File: rtl/i2c_cmdq_fifo.sv
module i2c_cmdq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o,
  output logic             push_drop_o,
  output logic             pop_drop_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full        = (level_q == LVL_W'(DEPTH));
  assign empty_o     = (level_q == '0);
  // full/empty are judged on the count at the start of the cycle
  assign do_push     = push_i & ~full & ~flush_i;
  assign do_pop      = pop_i & ~empty_o & ~flush_i;
  assign push_drop_o = push_i & full & ~flush_i;
  assign pop_drop_o  = pop_i & empty_o & ~flush_i;
  assign data_o      = mem[rptr_q];
  assign level_o     = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      level_q <= level_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end
endmodule

// File: rtl/i2c_cmdq_status.sv
module i2c_cmdq_status #(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_thresh_i,
  input  logic [LVL_W-1:0] rx_thresh_i,
  input  logic             tx_drop_i,
  input  logic             rx_drop_i,
  input  logic             rx_under_i,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             tx_over_o,
  output logic             rx_over_o,
  output logic             rx_under_o
);
  assign tx_empty_o = (tx_level_i <= tx_thresh_i);
  assign rx_full_o  = (rx_level_i > rx_thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_over_o  <= 1'b0;
      rx_over_o  <= 1'b0;
      rx_under_o <= 1'b0;
    end else begin
      tx_over_o  <= tx_drop_i;
      rx_over_o  <= rx_drop_i;
      rx_under_o <= rx_under_i;
    end
  end
endmodule

// File: rtl/i2c_cmdq.sv
module i2c_cmdq
  import i2c_cmdq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [LVL_W-1:0]  tx_thresh_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_data_o,
  input  logic              cmd_ready_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              abort_i,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              tx_over_o,
  output logic              rx_under_o,
  output logic              rx_over_o
);
  cmd_t              wr_cmd, head_cmd;
  logic              tx_empty_q, rx_empty;
  logic              tx_drop, tx_pop_drop, rx_drop, rx_under;
  logic [BYTE_W-1:0] rx_head;
  logic [BYTE_W-1:0] rd_data_q;

  assign wr_cmd = cmd_t'(wr_data_i);

  i2c_cmdq_fifo #(.W(CMD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (abort_i),
    .push_i      (wr_en_i),
    .data_i      (wr_cmd),
    .pop_i       (cmd_ready_i),
    .data_o      (head_cmd),
    .level_o     (tx_level_o),
    .empty_o     (tx_empty_q),
    .push_drop_o (tx_drop),
    .pop_drop_o  (tx_pop_drop)
  );

  i2c_cmdq_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (abort_i),
    .push_i      (rx_valid_i),
    .data_i      (rx_byte_i),
    .pop_i       (rd_en_i),
    .data_o      (rx_head),
    .level_o     (rx_level_o),
    .empty_o     (rx_empty),
    .push_drop_o (rx_drop),
    .pop_drop_o  (rx_under)
  );

  i2c_cmdq_status #(.LVL_W(LVL_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_level_i  (tx_level_o),
    .rx_level_i  (rx_level_o),
    .tx_thresh_i (tx_thresh_i),
    .rx_thresh_i (rx_thresh_i),
    .tx_drop_i   (tx_drop),
    .rx_drop_i   (rx_drop),
    .rx_under_i  (rx_under),
    .tx_empty_o  (tx_empty_o),
    .rx_full_o   (rx_full_o),
    .tx_over_o   (tx_over_o),
    .rx_over_o   (rx_over_o),
    .rx_under_o  (rx_under_o)
  );

  // engine pop on an empty queue is harmless; cmd_valid_o gates it
  logic unused_pop_drop;
  assign unused_pop_drop = tx_pop_drop;

  assign cmd_valid_o = ~tx_empty_q;
  assign cmd_data_o  = head_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rd_data_q <= '0;
    else if (rd_en_i && !abort_i) rd_data_q <= rx_empty ? '0 : rx_head;
  end
  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/i2c_cmdq_chk.sv
module i2c_cmdq_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       rd_data_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic             rx_valid_i,
  input logic             abort_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             tx_over_o,
  input logic             rx_under_o,
  input logic             rx_over_o
);
  AST_TX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= LVL_W'(DEPTH) && rx_level_o <= LVL_W'(DEPTH)); // R4

  AST_CMD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == (tx_level_o != '0)); // R1

  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_level_o == '0 && rx_level_o == '0)); // R7

  AST_TX_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !abort_i && tx_level_o == LVL_W'(DEPTH)) |=> tx_over_o); // R8

  AST_RX_UNDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !abort_i && rx_level_o == '0) |=> (rx_under_o && rd_data_o == '0)); // R9

  AST_RX_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !abort_i && rx_level_o == LVL_W'(DEPTH)) |=> rx_over_o); // R10

  AST_TX_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cmd_valid_o && cmd_ready_i && !abort_i && tx_level_o < LVL_W'(DEPTH))
      |=> $stable(tx_level_o)); // R11
endmodule

bind i2c_cmdq i2c_cmdq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .rx_valid_i  (rx_valid_i),
  .abort_i     (abort_i),
  .tx_level_o  (tx_level_o),
  .rx_level_o  (rx_level_o),
  .tx_over_o   (tx_over_o),
  .rx_under_o  (rx_under_o),
  .rx_over_o   (rx_over_o)
);

// File: tb/tb_i2c_cmdq.sv
`timescale 1ns/1ps
module tb_i2c_cmdq;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             wr_en_i, rd_en_i, cmd_ready_i, rx_valid_i, abort_i;
  logic [8:0]       wr_data_i;
  logic [7:0]       rx_byte_i, rd_data_o;
  logic [LVL_W-1:0] tx_thresh_i, rx_thresh_i, tx_level_o, rx_level_o;
  logic             cmd_valid_o, tx_empty_o, rx_full_o, tx_over_o, rx_under_o, rx_over_o;
  logic [8:0]       cmd_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int tx_q[$];
  int rx_q[$];

  always #2 clk_i = ~clk_i;

  i2c_cmdq #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    wr_en_i = 0; rd_en_i = 0; cmd_ready_i = 0; rx_valid_i = 0; abort_i = 0;
  endtask

  // levels plus a sweep of every threshold encoding
  task automatic check_lvls();
    chk(tx_level_o == tx_q.size(), "R4 tx level", tx_level_o, tx_q.size());
    chk(rx_level_o == rx_q.size(), "R4 rx level", rx_level_o, rx_q.size());
    chk(cmd_valid_o == (tx_q.size() != 0), "R1 cmd_valid", cmd_valid_o, tx_q.size() != 0);
    for (int t = 0; t < (1 << LVL_W); t++) begin
      tx_thresh_i = LVL_W'(t);
      rx_thresh_i = LVL_W'(t);
      #0.2;
      chk(tx_empty_o == (tx_q.size() <= t), "R5 tx_empty", tx_empty_o, tx_q.size() <= t);
      chk(rx_full_o == (rx_q.size() > t), "R6 rx_full", rx_full_o, rx_q.size() > t);
    end
  endtask

  task automatic push_cmd(input logic [8:0] v);
    wr_en_i = 1; wr_data_i = v;
    step();
    if (tx_q.size() < DEPTH) tx_q.push_back(int'(v));
  endtask

  task automatic push_rx(input logic [7:0] v);
    rx_valid_i = 1; rx_byte_i = v;
    step();
    if (rx_q.size() < DEPTH) rx_q.push_back(int'(v));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    wr_en_i = 0; rd_en_i = 0; cmd_ready_i = 0; rx_valid_i = 0; abort_i = 0;
    wr_data_i = '0; rx_byte_i = '0; tx_thresh_i = '0; rx_thresh_i = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #1;
    // reset state, R4
    chk(rd_data_o == 0, "R4 reset rd_data", rd_data_o, 0);
    chk({tx_over_o, rx_over_o, rx_under_o} == 0, "R4 reset events",
        {tx_over_o, rx_over_o, rx_under_o}, 0);
    check_lvls();

    // R1 / R2 fill with mixed entries, then overflow R8
    for (int i = 0; i < DEPTH; i++) begin
      push_cmd((i % 2) ? 9'h100 | 9'(i) : 9'(8'hA0 + i));
      chk(tx_over_o == 0, "R8 no overflow", tx_over_o, 0);
      check_lvls();
    end
    wr_en_i = 1; wr_data_i = 9'h055; cmd_ready_i = 1; // pop in same cycle: still dropped
    step();
    void'(tx_q.pop_front());
    chk(tx_over_o == 1, "R8 tx_over pulse", tx_over_o, 1);
    chk(tx_level_o == DEPTH - 1, "R8 write dropped", tx_level_o, DEPTH - 1);
    step();
    chk(tx_over_o == 0, "R8 pulse one cycle", tx_over_o, 0);
    while (tx_q.size() > 0) begin
      chk(cmd_data_o == 9'(tx_q[0]), "R1 R2 cmd order", cmd_data_o, tx_q[0]);
      chk(cmd_data_o[8] == tx_q[0][8], "R2 read flag", cmd_data_o[8], tx_q[0][8]);
      cmd_ready_i = 1;
      step();
      void'(tx_q.pop_front());
      check_lvls();
    end

    // R3 / R6 receive fill, overflow R10
    for (int i = 0; i < DEPTH; i++) begin
      push_rx(8'(8'h30 + 7 * i));
      check_lvls();
    end
    push_rx(8'hEE);
    chk(rx_over_o == 1, "R10 rx_over pulse", rx_over_o, 1);
    chk(rx_level_o == DEPTH, "R10 byte dropped", rx_level_o, DEPTH);
    step();
    chk(rx_over_o == 0, "R10 pulse one cycle", rx_over_o, 0);
    while (rx_q.size() > 0) begin
      rd_en_i = 1;
      step();
      chk(rd_data_o == 8'(rx_q[0]), "R3 rx order", rd_data_o, rx_q[0]);
      chk(rx_under_o == 0, "R9 no underflow", rx_under_o, 0);
      void'(rx_q.pop_front());
      check_lvls();
    end
    rd_en_i = 1;
    step();
    chk(rd_data_o == 0, "R9 empty read zero", rd_data_o, 0);
    chk(rx_under_o == 1, "R9 rx_under pulse", rx_under_o, 1);
    step();
    chk(rx_under_o == 0, "R9 pulse one cycle", rx_under_o, 0);

    // R11 balanced push and pop
    push_cmd(9'h011); push_cmd(9'h122);
    push_rx(8'h5A); push_rx(8'hA5);
    wr_en_i = 1; wr_data_i = 9'h033; cmd_ready_i = 1;
    rx_valid_i = 1; rx_byte_i = 8'h77; rd_en_i = 1;
    step();
    chk(rd_data_o == 8'h5A, "R11 rd during push", rd_data_o, 8'h5A);
    void'(tx_q.pop_front()); tx_q.push_back(9'h033);
    void'(rx_q.pop_front()); rx_q.push_back(8'h77);
    chk(tx_level_o == 2, "R11 tx balanced", tx_level_o, 2);
    chk(rx_level_o == 2, "R11 rx balanced", rx_level_o, 2);
    check_lvls();

    // R7 abort flushes, same-cycle ops ignored
    push_cmd(9'h044);
    abort_i = 1; wr_en_i = 1; wr_data_i = 9'h0FF; rx_valid_i = 1; rx_byte_i = 8'hFF; rd_en_i = 1;
    step();
    tx_q.delete(); rx_q.delete();
    chk(rd_data_o == 8'h5A, "R7 read ignored", rd_data_o, 8'h5A);
    chk({tx_over_o, rx_over_o, rx_under_o} == 0, "R7 no events",
        {tx_over_o, rx_over_o, rx_under_o}, 0);
    check_lvls();
    push_cmd(9'h0C3);
    chk(cmd_data_o == 9'h0C3, "R7 head after flush", cmd_data_o, 9'h0C3);
    push_rx(8'h3C);
    rd_en_i = 1;
    step();
    void'(rx_q.pop_front());
    chk(rd_data_o == 8'h3C, "R7 rx head after flush", rd_data_o, 8'h3C);
    check_lvls();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule